// File: doc/BRIEF.md
# Two-Level Short-Descriptor Table Walker

The block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a translation table in memory. A request carries the address, the kind of access (read, write or instruction fetch) and whether the access comes from user mode. The level-1 table base and a 32-bit domain control word are configuration inputs. Descriptors are fetched through a simple read port that has one read outstanding at a time. The walker raises `mem_req` with an address and waits for a one-cycle `mem_valid` that carries the data or an error flag.

A level-1 descriptor either maps a 1 MB section directly or points to a coarse or fine level-2 table. A level-2 descriptor maps a 64 KB, 4 KB or 1 KB page. Each level-1 descriptor selects one of sixteen domains. The 2-bit domain field in the control word decides three cases: the access is blocked, the page permissions apply (client), or full access is given (manager). Every walk ends with a one-cycle `done` pulse. With it come either the physical address, the read/write/execute permissions and the page size, or a fault with its type, domain and level. These results stay on the outputs until the next walk finishes.

Top module: `sdw_walker`

## Requirements
- R1: An accepted request fetches its level-1 descriptor from `{cfg_l1_base, va[31:20], 2'b00}`. `mem_req` stays high with a stable `mem_addr` until `mem_valid`, and is only high while `busy` is high.
- R2: Level-1 descriptor bits [1:0] give the kind: 0 is a translation fault (type 1) at level 1, 2 is a section, 1 is a coarse table and 3 is a fine table. Bits [8:5] give the domain d, which is reported on every fault after the level-1 fetch.
- R3: The domain field is `cfg_dacr[2d+1:2d]`. A value of 0 or 2 raises a domain fault (type 2) with no level-2 fetch. The fault is at level 1 for a section and at level 2 for a table.
- R4: A section hit gives PA = {desc[31:20], va[19:0]}, takes AP from desc[11:10] and reports page size code 3 (1 MB).
- R5: The level-2 address is {desc[31:10], va[19:12], 2'b00} for a coarse table and {desc[31:12], va[19:10], 2'b00} for a fine table.
- R6: Level-2 kind 1 is a 64 KB page (size code 2), with PA = {desc[31:16], va[15:0]} and AP at desc bits [5+2k:4+2k], k = va[15:14]. Kind 2 is a 4 KB page (size code 1), with PA = {desc[31:12], va[11:0]} and k = va[11:10].
- R7: Level-2 kind 0 is a translation fault at level 2. Kind 3 in a fine table is a 1 KB page (size code 0) with PA = {desc[31:10], va[9:0]}. Kind 3 in a coarse table is a 4 KB page when `cfg_ext_small` is 1 and a translation fault otherwise. Kind 3 takes AP from desc[5:4].
- R8: A manager domain (field 3) grants read, write and execute whatever AP holds.
- R9: In a client domain (field 1) the grants depend on AP. AP 0 grants nothing. AP 1 grants read/write to privileged accesses only. AP 2 grants read/write to privileged accesses and read only to user accesses. AP 3 grants read/write to all. Execute is granted whenever read or write is granted.
- R10: An access (`req_acc` 0 read, 1 write, 2 fetch) that the grants do not allow raises a permission fault (type 3) at the current level.
- R11: A descriptor read returned with `mem_err` raises an external fault (type 4). It is at level 1 with domain 0 for a level-1 fetch, and at level 2 with the level-1 domain for a level-2 fetch.
- R12: `done` is a one-cycle pulse and `busy` is low while it is high. A request while busy is ignored. Results hold until the next `done`. With a memory answer L cycles after `mem_req` rises, `done` comes n*(L+1)+1 cycles after the accepting edge for an n-level walk.
- R13: A hit reports fault type 0, level 0 and domain 0. A fault reports PA 0, no permissions and size code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| cfg_l1_base | input | 18 | Level-1 table base, address bits [31:14] |
| cfg_dacr | input | 32 | Sixteen 2-bit domain fields |
| cfg_ext_small | input | 1 | Coarse-table kind 3 means a 4 KB page |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_valid | input | 1 | Read data valid (one cycle) |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Read failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result pulse |
| pa | output | 32 | Physical address |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| page_size | output | 2 | 0: 1 KB, 1: 4 KB, 2: 64 KB, 3: 1 MB |
| fault_type | output | 3 | 0 none, 1 translation, 2 domain, 3 permission, 4 external |
| fault_domain | output | 4 | Domain of the fault |
| fault_level | output | 2 | Level of the fault (0 on a hit) |

## Verification
Every result is due a fixed number of cycles after its request. With the bench memory answering two cycles after `mem_req` rises, a walk that ends at level 1 raises `done` at the 4th falling edge after the accepting clock edge. A walk that reads both levels raises it at the 7th. The bench counts falling edges from acceptance to `done` and compares that count with the n*(L+1)+1 rule. It reads the results only on the falling edge where `done` is high. One cycle later it reads them again to confirm that the pulse has ended and the values hold. It also logs every descriptor address the memory serves. This checks both the fetch order and that a domain fault skips the level-2 read.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int DESC_W     = 32;
  localparam int DOM_W      = 4;
  localparam int DOM_N      = 1 << DOM_W;
  localparam int DACR_W     = 2 * DOM_N;
  localparam int L1_BASE_W  = 18;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [2:0] {FT_NONE = 3'd0, FT_TRANS = 3'd1, FT_DOMAIN = 3'd2,
                            FT_PERM = 3'd3, FT_EXT = 3'd4} fault_e;
  typedef enum logic [1:0] {PG_1K = 2'd0, PG_4K = 2'd1, PG_64K = 2'd2, PG_1M = 2'd3} pgsz_e;
  typedef enum logic [2:0] {S_IDLE, S_L1, S_L1DEC, S_L2, S_L2DEC} walk_e;
endpackage

// File: rtl/sdw_l1_decode.sv
module sdw_l1_decode
  import sdw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [19:0]       va_lo,
  input  logic [DACR_W-1:0] dacr,
  output logic [1:0]        kind,
  output logic [DOM_W-1:0]  dom,
  output logic [1:0]        dfield,
  output logic [31:0]       sec_pa,
  output logic [1:0]        sec_ap,
  output logic [31:0]       l2_addr
);
  assign kind   = desc[1:0];
  assign dom    = desc[8:5];
  assign dfield = dacr[{dom, 1'b0} +: 2];
  assign sec_pa = {desc[31:20], va_lo};
  assign sec_ap = desc[11:10];
  // coarse tables index with va[19:12], fine tables with va[19:10]
  assign l2_addr = (kind == 2'd1) ? {desc[31:10], va_lo[19:12], 2'b00}
                                  : {desc[31:12], va_lo[19:10], 2'b00};
endmodule

// File: rtl/sdw_l2_decode.sv
module sdw_l2_decode
  import sdw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [15:0]       va_lo,
  input  logic              coarse,
  input  logic              ext_small,
  output logic [31:0]       pa,
  output logic [1:0]        ap,
  output logic [1:0]        size,
  output logic              bad
);
  logic [1:0] ap_sub [4];

  for (genvar k = 0; k < 4; k++) begin : g_ap
    assign ap_sub[k] = desc[4 + 2*k +: 2];
  end

  always_comb begin
    pa   = '0;
    ap   = ap_sub[0];
    size = PG_4K;
    bad  = 1'b0;
    case (desc[1:0])
      2'd1: begin
        pa   = {desc[31:16], va_lo[15:0]};
        ap   = ap_sub[va_lo[15:14]];
        size = PG_64K;
      end
      2'd2: begin
        pa   = {desc[31:12], va_lo[11:0]};
        ap   = ap_sub[va_lo[11:10]];
        size = PG_4K;
      end
      2'd3: begin
        if (!coarse) begin
          pa   = {desc[31:10], va_lo[9:0]};
          size = PG_1K;
        end else if (ext_small) begin
          pa   = {desc[31:12], va_lo[11:0]};
          size = PG_4K;
        end else begin
          bad = 1'b1;
        end
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/sdw_perm.sv
module sdw_perm
  import sdw_pkg::*;
(
  input  logic [1:0] ap,
  input  logic [1:0] dfield,
  input  logic       user,
  input  logic [1:0] acc,
  output logic       r,
  output logic       w,
  output logic       x,
  output logic       ok
);
  always_comb begin
    if (dfield == 2'd3) begin
      r = 1'b1;
      w = 1'b1;
    end else begin
      case (ap)
        2'd1:    begin r = !user; w = !user; end
        2'd2:    begin r = 1'b1;  w = !user; end
        2'd3:    begin r = 1'b1;  w = 1'b1;  end
        default: begin r = 1'b0;  w = 1'b0;  end
      endcase
    end
    x = r | w;
    case (acc)
      ACC_WRITE: ok = w;
      ACC_FETCH: ok = x;
      default:   ok = r;
    endcase
  end
endmodule

// File: rtl/sdw_walker.sv
module sdw_walker
  import sdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_va,
  input  logic [1:0]           req_acc,
  input  logic                 req_user,
  input  logic [L1_BASE_W-1:0] cfg_l1_base,
  input  logic [DACR_W-1:0]    cfg_dacr,
  input  logic                 cfg_ext_small,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_valid,
  input  logic [DESC_W-1:0]    mem_rdata,
  input  logic                 mem_err,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        pa,
  output logic                 perm_r,
  output logic                 perm_w,
  output logic                 perm_x,
  output logic [1:0]           page_size,
  output logic [2:0]           fault_type,
  output logic [DOM_W-1:0]     fault_domain,
  output logic [1:0]           fault_level
);
  walk_e             state;
  logic [19:0]       va_q;
  logic [1:0]        acc_q;
  logic              user_q;
  logic [DESC_W-1:0] d_q;
  logic              err_q;
  logic [DOM_W-1:0]  dom_q;
  logic [1:0]        dfield_q;
  logic              coarse_q;

  logic [1:0]       l1_kind, l1_dfield, sec_ap, l2_ap, l2_size;
  logic [DOM_W-1:0] l1_dom;
  logic [31:0]      sec_pa, l2_addr, l2_pa;
  logic             l2_bad;
  logic             g_r, g_w, g_x, g_ok;
  logic             at_l2;

  sdw_l1_decode u_l1 (
    .desc(d_q), .va_lo(va_q), .dacr(cfg_dacr), .kind(l1_kind), .dom(l1_dom),
    .dfield(l1_dfield), .sec_pa(sec_pa), .sec_ap(sec_ap), .l2_addr(l2_addr)
  );

  sdw_l2_decode u_l2 (
    .desc(d_q), .va_lo(va_q[15:0]), .coarse(coarse_q), .ext_small(cfg_ext_small),
    .pa(l2_pa), .ap(l2_ap), .size(l2_size), .bad(l2_bad)
  );

  assign at_l2 = (state == S_L2DEC);

  sdw_perm u_perm (
    .ap(at_l2 ? l2_ap : sec_ap), .dfield(at_l2 ? dfield_q : l1_dfield),
    .user(user_q), .acc(acc_q), .r(g_r), .w(g_w), .x(g_x), .ok(g_ok)
  );

  // outcome of the current decode cycle
  logic             fin;
  logic [2:0]       fin_ft;
  logic [1:0]       fin_lvl;
  logic [DOM_W-1:0] fin_dom;
  logic [31:0]      fin_pa;
  logic [1:0]       fin_sz;

  always_comb begin
    fin     = 1'b0;
    fin_ft  = FT_NONE;
    fin_lvl = 2'd0;
    fin_dom = '0;
    fin_pa  = '0;
    fin_sz  = PG_1K;
    if (state == S_L1DEC) begin
      fin = 1'b1;
      if (err_q) begin
        fin_ft = FT_EXT; fin_lvl = 2'd1;
      end else if (l1_kind == 2'd0) begin
        fin_ft = FT_TRANS; fin_lvl = 2'd1; fin_dom = l1_dom;
      end else if (!l1_dfield[0]) begin
        fin_ft = FT_DOMAIN; fin_dom = l1_dom;
        fin_lvl = (l1_kind == 2'd2) ? 2'd1 : 2'd2;
      end else if (l1_kind == 2'd2) begin
        if (g_ok) begin
          fin_pa = sec_pa; fin_sz = PG_1M;
        end else begin
          fin_ft = FT_PERM; fin_lvl = 2'd1; fin_dom = l1_dom;
        end
      end else begin
        fin = 1'b0;
      end
    end else if (state == S_L2DEC) begin
      fin = 1'b1;
      if (err_q || l2_bad || !g_ok) begin
        fin_ft  = err_q ? FT_EXT : (l2_bad ? FT_TRANS : FT_PERM);
        fin_lvl = 2'd2;
        fin_dom = dom_q;
      end else begin
        fin_pa = l2_pa; fin_sz = l2_size;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      va_q <= '0; acc_q <= '0; user_q <= 1'b0; d_q <= '0; err_q <= 1'b0;
      dom_q <= '0; dfield_q <= '0; coarse_q <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0; busy <= 1'b0; done <= 1'b0;
      pa <= '0; perm_r <= 1'b0; perm_w <= 1'b0; perm_x <= 1'b0; page_size <= '0;
      fault_type <= '0; fault_domain <= '0; fault_level <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q     <= req_va[19:0];
          acc_q    <= req_acc;
          user_q   <= req_user;
          mem_addr <= {cfg_l1_base, req_va[31:20], 2'b00};
          mem_req  <= 1'b1;
          busy     <= 1'b1;
          state    <= S_L1;
        end
        S_L1, S_L2: if (mem_valid) begin
          d_q     <= mem_rdata;
          err_q   <= mem_err;
          mem_req <= 1'b0;
          state   <= (state == S_L1) ? S_L1DEC : S_L2DEC;
        end
        S_L1DEC: begin
          mem_addr <= l2_addr;
          mem_req  <= 1'b1;
          dom_q    <= l1_dom;
          dfield_q <= l1_dfield;
          coarse_q <= (l1_kind == 2'd1);
          state    <= S_L2;
        end
        default: state <= S_IDLE;
      endcase
      if (fin) begin
        state        <= S_IDLE;
        mem_req      <= 1'b0;
        busy         <= 1'b0;
        done         <= 1'b1;
        pa           <= fin_pa;
        page_size    <= fin_sz;
        fault_type   <= fin_ft;
        fault_level  <= fin_lvl;
        fault_domain <= fin_dom;
        perm_r       <= (fin_ft == FT_NONE) && g_r;
        perm_w       <= (fin_ft == FT_NONE) && g_w;
        perm_x       <= (fin_ft == FT_NONE) && g_x;
      end
    end
  end
endmodule

// File: rtl/sdw_walker_chk.sv
module sdw_walker_chk
  import sdw_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic [31:0]      mem_addr,
  input logic             mem_valid,
  input logic             busy,
  input logic             done,
  input logic [31:0]      pa,
  input logic             perm_r,
  input logic             perm_w,
  input logic             perm_x,
  input logic [2:0]       fault_type,
  input logic [1:0]       fault_level
);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r1_req_in_walk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  a_r9_exec_follows: assert property (@(posedge clk) disable iff (rst)
    (done && fault_type == 3'd0) |-> (perm_x == (perm_r || perm_w)) && perm_x);

  a_r13_fault_clears: assert property (@(posedge clk) disable iff (rst)
    (done && fault_type != 3'd0) |->
      (!perm_r && !perm_w && !perm_x && pa == 32'd0 && fault_level != 2'd0));

  a_r12_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pa) && $stable(fault_type) && $stable(fault_level)));
endmodule

bind sdw_walker sdw_walker_chk i_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .busy(busy), .done(done), .pa(pa), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
  .fault_type(fault_type), .fault_level(fault_level)
);

// File: tb/test_sdw_walker.sv
module test_sdw_walker;
  import sdw_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          LAT        = 2;
  localparam logic [17:0] BASE       = 18'h00010;   // table at 0x0004_0000
  localparam logic [31:0] DACR       = 32'h0000_048D; // d0 client, d1 manager, d2 none, d3 reserved, d5 client

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        user;
    logic        ext;
    logic [31:0] d1;
    logic [31:0] l2a;
    logic [31:0] d2;
    logic [2:0]  ft;
    logic [1:0]  lvl;
    logic [3:0]  dom;
    logic [31:0] pa;
    logic [2:0]  rwx;
    logic [1:0]  sz;
    logic [1:0]  levels;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 2'd0, 1'b1, 1'b0, 32'h8A30_0C02, 32'h0, 32'h0, 3'd0, 2'd0, 4'd0, 32'h8A34_5678, 3'b111, 2'd3, 2'd1}, // R4 R9 AP3
    '{32'h0050_0010, 2'd1, 1'b1, 1'b0, 32'h0010_04A2, 32'h0, 32'h0, 3'd3, 2'd1, 4'd5, 32'h0, 3'b000, 2'd0, 2'd1},          // R10 AP1 user
    '{32'h0050_0010, 2'd1, 1'b0, 1'b0, 32'h0010_04A2, 32'h0, 32'h0, 3'd0, 2'd0, 4'd0, 32'h0010_0010, 3'b111, 2'd3, 2'd1}, // R9 AP1 priv
    '{32'h0060_0000, 2'd0, 1'b1, 1'b0, 32'h0200_0802, 32'h0, 32'h0, 3'd0, 2'd0, 4'd0, 32'h0200_0000, 3'b101, 2'd3, 2'd1}, // R9 AP2 user read
    '{32'h0060_0004, 2'd1, 1'b1, 1'b0, 32'h0200_0802, 32'h0, 32'h0, 3'd3, 2'd1, 4'd0, 32'h0, 3'b000, 2'd0, 2'd1},          // R10 AP2 user write
    '{32'h0070_ABCD, 2'd2, 1'b1, 1'b0, 32'h3000_0022, 32'h0, 32'h0, 3'd0, 2'd0, 4'd0, 32'h3000_ABCD, 3'b111, 2'd3, 2'd1}, // R8 manager
    '{32'h0080_0000, 2'd0, 1'b0, 1'b0, 32'h4000_0002, 32'h0, 32'h0, 3'd3, 2'd1, 4'd0, 32'h0, 3'b000, 2'd0, 2'd1},          // R9 AP0
    '{32'h0090_0000, 2'd0, 1'b0, 1'b0, 32'h0000_00A0, 32'h0, 32'h0, 3'd1, 2'd1, 4'd5, 32'h0, 3'b000, 2'd0, 2'd1},          // R2 kind 0
    '{32'h0D00_0000, 2'd0, 1'b0, 1'b0, 32'h5000_0042, 32'h0, 32'h0, 3'd2, 2'd1, 4'd2, 32'h0, 3'b000, 2'd0, 2'd1},          // R3 section
    '{32'h0E00_0000, 2'd0, 1'b0, 1'b0, 32'h0008_0061, 32'h0, 32'h0, 3'd2, 2'd2, 4'd3, 32'h0, 3'b000, 2'd0, 2'd1},          // R3 table
    '{32'h00A3_4567, 2'd1, 1'b1, 1'b0, 32'h0008_0401, 32'h0008_04D0, 32'h7654_31C2, 3'd0, 2'd0, 4'd0, 32'h7654_3567, 3'b111, 2'd1, 2'd2}, // R5 R6 4K
    '{32'h00A3_C123, 2'd0, 1'b1, 1'b0, 32'h0008_0401, 32'h0008_04F0, 32'hABCD_0BF1, 3'd0, 2'd0, 4'd0, 32'hABCD_C123, 3'b101, 2'd2, 2'd2}, // R6 64K
    '{32'h00A3_C123, 2'd1, 1'b1, 1'b0, 32'h0008_0401, 32'h0008_04F0, 32'hABCD_0BF1, 3'd3, 2'd2, 4'd0, 32'h0, 3'b000, 2'd0, 2'd2},          // R10 level 2
    '{32'h00B5_6789, 2'd0, 1'b0, 1'b0, 32'h0009_10A3, 32'h0009_1564, 32'h1111_2413, 3'd0, 2'd0, 4'd0, 32'h1111_2789, 3'b111, 2'd0, 2'd2}, // R5 R7 1K
    '{32'h00A0_1ABC, 2'd0, 1'b0, 1'b0, 32'h0008_0401, 32'h0008_0404, 32'h2222_2033, 3'd1, 2'd2, 4'd0, 32'h0, 3'b000, 2'd0, 2'd2},          // R7 no ext
    '{32'h00A0_1ABC, 2'd2, 1'b1, 1'b1, 32'h0008_0401, 32'h0008_0404, 32'h2222_2033, 3'd0, 2'd0, 4'd0, 32'h2222_2ABC, 3'b111, 2'd1, 2'd2}, // R7 ext
    '{32'h00B0_0000, 2'd0, 1'b0, 1'b0, 32'h0009_10A3, 32'h0009_1000, 32'h3333_3330, 3'd1, 2'd2, 4'd5, 32'h0, 3'b000, 2'd0, 2'd2},          // R7 kind 0
    '{32'h00C0_8000, 2'd2, 1'b1, 1'b0, 32'h000A_0021, 32'h000A_0020, 32'h4444_0001, 3'd0, 2'd0, 4'd0, 32'h4444_8000, 3'b111, 2'd2, 2'd2}  // R8 via table
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_user, cfg_ext_small;
  logic [31:0] req_va;
  logic [1:0]  req_acc;
  logic        mem_req, mem_valid, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        busy, done, perm_r, perm_w, perm_x;
  logic [31:0] pa;
  logic [1:0]  page_size, fault_level;
  logic [2:0]  fault_type;
  logic [3:0]  fault_domain;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] fetch_log [0:255];
  int          fetch_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdw_walker i_sdw_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
    .req_user(req_user), .cfg_l1_base(BASE), .cfg_dacr(DACR), .cfg_ext_small(cfg_ext_small),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .busy(busy), .done(done), .pa(pa), .perm_r(perm_r), .perm_w(perm_w),
    .perm_x(perm_x), .page_size(page_size), .fault_type(fault_type),
    .fault_domain(fault_domain), .fault_level(fault_level)
  );

  // memory model: answers LAT falling edges after it first sees a request
  initial begin
    int  cnt = 0;
    bit  served = 0;
    mem_valid = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      mem_err   = 1'b0;
      if (!mem_req) begin
        served = 0; cnt = 0;
      end else if (!served) begin
        if (cnt == 0) begin
          fetch_log[fetch_cnt % 256] = mem_addr;
          fetch_cnt++;
        end
        cnt++;
        if (cnt == LAT) begin
          mem_valid = 1'b1;
          mem_rdata = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
          mem_err   = (mem_addr == err_addr);
          served    = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] va);
    return {BASE, va[31:20], 2'b00};
  endfunction

  // starts a walk and waits for done; spam re-raises req_valid during the walk
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                      input logic ext, input bit spam, output int cyc, output int nf,
                      output int first);
    @(negedge clk);
    cfg_ext_small = ext; req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
    first = fetch_cnt;
    cyc = 0;
    while (cyc < 60) begin
      @(negedge clk);
      cyc++;
      req_valid = spam && (cyc < 4);
      if (spam) req_va = 32'h1234_5678;
      if (cyc == 1) chk("R12", "busy during walk", {31'd0, busy}, 32'd1);
      if (done) break;
    end
    nf = fetch_cnt - first;
  endtask

  task automatic check_result(input string tag, input vec_t v, input int cyc, input int nf, input int first);
    chk(tag, "fault_type",   {29'd0, fault_type},   {29'd0, v.ft});
    chk(tag, "fault_level",  {30'd0, fault_level},  {30'd0, v.lvl});
    chk(tag, "fault_domain", {28'd0, fault_domain}, {28'd0, v.dom});
    chk(tag, "pa",           pa,                    v.pa);
    chk(tag, "rwx",          {29'd0, perm_r, perm_w, perm_x}, {29'd0, v.rwx});
    chk(tag, "page_size",    {30'd0, page_size},    {30'd0, v.sz});
    chk("R12", "cycles to done", cyc, v.levels * (LAT + 1) + 1);
    chk("R3", "fetch count", nf, {30'd0, v.levels});
    chk("R1", "level-1 address", fetch_log[first % 256], l1_addr(v.va));
    if (v.levels == 2) chk("R5", "level-2 address", fetch_log[(first + 1) % 256], v.l2a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R12 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cyc, nf, first;
    vec_t v;
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_acc = '0; req_user = 1'b0; cfg_ext_small = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "reset busy", {31'd0, busy}, 32'd0);
    chk("R13", "reset done", {31'd0, done}, 32'd0);
    chk("R1",  "reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R13", "reset fault_type", {29'd0, fault_type}, 32'd0);
    rst = 1'b0;

    // table walk of vectors (R2..R10 per row comments)
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      mem_img.delete();
      mem_img[l1_addr(v.va)] = v.d1;
      if (v.levels == 2) mem_img[v.l2a] = v.d2;
      walk(v.va, v.acc, v.user, v.ext, 1'b0, cyc, nf, first);
      check_result($sformatf("vec%0d", i), v, cyc, nf, first);
      @(negedge clk);
      chk("R12", "done one cycle", {31'd0, done}, 32'd0);
      chk("R12", "pa holds", pa, v.pa);
    end

    // R11 external error on the level-1 read
    mem_img.delete();
    err_addr = l1_addr(32'h0F00_0000);
    walk(32'h0F00_0000, 2'd0, 1'b0, 1'b0, 1'b0, cyc, nf, first);
    chk("R11", "l1 err type",  {29'd0, fault_type},  32'd4);
    chk("R11", "l1 err level", {30'd0, fault_level}, 32'd1);
    chk("R11", "l1 err dom",   {28'd0, fault_domain}, 32'd0);
    chk("R11", "l1 err fetches", nf, 32'd1);

    // R11 external error on the level-2 read, domain from level 1
    mem_img.delete();
    mem_img[l1_addr(32'h00B5_6789)] = 32'h0009_10A3;
    err_addr = 32'h0009_1564;
    walk(32'h00B5_6789, 2'd0, 1'b0, 1'b0, 1'b0, cyc, nf, first);
    chk("R11", "l2 err type",  {29'd0, fault_type},  32'd4);
    chk("R11", "l2 err level", {30'd0, fault_level}, 32'd2);
    chk("R11", "l2 err dom",   {28'd0, fault_domain}, 32'd5);
    chk("R13", "l2 err pa",    pa, 32'd0);
    err_addr = 32'hFFFF_FFFF;

    // R12 requests while busy are ignored
    v = VECS[10];
    mem_img.delete();
    mem_img[l1_addr(v.va)] = v.d1;
    mem_img[v.l2a] = v.d2;
    walk(v.va, v.acc, v.user, v.ext, 1'b1, cyc, nf, first);
    chk("R12", "busy req ignored pa", pa, v.pa);
    chk("R12", "busy req ignored cycles", cyc, v.levels * (LAT + 1) + 1);
    chk("R12", "busy req ignored fetches", nf, 32'd2);
    repeat (3) @(negedge clk);
    chk("R12", "idle after walk", {30'd0, busy, done}, 32'd0);
    chk("R12", "no extra fetch", fetch_cnt - first, 32'd2);
    chk("R12", "result held", pa, v.pa);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule